// File: doc/BRIEF.md
# UART Register Front End with Receive Queue and Interrupt Fan-Out

This block is the software-facing register layer of a serial port. A simple register bus (byte offset, write data, write strobe, read strobe, registered read data) reaches a set of configuration registers: baud divisors, line and control settings, an infrared low-power divisor, a queue level selector, an interrupt enable vector and a DMA control word. Incoming bytes arrive as a valid strobe with data and error flags, and they are stored in a receive queue whose depth and interrupt threshold follow the line settings. A data write hands a byte to the transmit side as a one-cycle strobe and counts it as pending until the transmitter reports that it is finished.

The block keeps a raw interrupt vector. The receive bit follows the queue fill against the threshold, and any bit can also be raised by event pulses from the rest of the port. Software clears bits by writing ones. The raw vector is ANDed with the enable vector and then with a fixed per-line mask to drive several interrupt outputs, so one shared line and several dedicated lines can serve different handlers. A loopback control bit disconnects the external receive input completely.

Top module: `uart_regfile`

## Requirements
- R1: After synchronous reset every register reads zero, the flag register reads 0x5 (bit 0 receive empty, bit 2 transmit empty, bit 1 receive full clear), and all interrupt lines are low.
- R2: The register index is bus_addr[7:2] and holds only when bus_addr[1:0] is zero. Index 8 keeps 8 bits, 9 keeps 16 bits, 10 keeps the low 6 bits, 11 (line) keeps 8 bits, 12 (control) keeps 16 bits, 13 (level) keeps 6 bits, 14 (enable) keeps 11 bits and 18 keeps 3 bits. Each reads back what it stored. Index 15 reads the raw vector and 16 reads raw AND enable.
- R3: Any write to index 1 zeroes the receive status register (bits 2:0 are the error flags {break, parity, framing} ORed in from stored bytes, bit 3 is overrun), whatever data is written.
- R4: Writes to the flag register (index 6), to an undefined index, or with a nonzero bus_addr[1:0] change no register.
- R5: The receive queue holds 16 entries when line bit 4 is set and 1 entry when it is clear. A byte that arrives while the queue is full is dropped and sets status bit 3. A read of index 0 returns {err[2:0], byte} of the oldest entry at bits 10:0 and removes it; on an empty queue it returns 0.
- R6: A line write that changes bit 4 empties both the receive queue and the transmit pending count. A line write that leaves bit 4 unchanged does not.
- R7: The receive threshold is 1 with the queue disabled. Otherwise level bits 2:0 select 2, 4, 8, 12 or 14 for codes 0 to 4, and 8 for codes 5 to 7.
- R8: Raw bit 4 is re-evaluated as (fill >= threshold) whenever the fill changes or a line or level write occurs, and otherwise holds.
- R9: An event pulse on hw_evt sets the matching raw bits. A write to index 17 then clears every raw bit that is set in the written value, and a clear wins over a same-cycle set.
- R10: A write to index 14 replaces the enable vector. Output line i goes high on the same clock edge as the state change when raw AND enable AND LINE_MASK slice i is nonzero.
- R11: While control bit 7 is set, rx_valid is ignored: no byte is stored and no status bit changes.
- R12: A write to index 0 pulses tx_strobe for one cycle with tx_byte equal to the low 8 data bits. It adds one pending byte unless the count already equals the queue depth, and each tx_done removes one. Flag bit 2 reads 1 exactly when nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; a data read also pops the receive queue |
| bus_rdata | output | 16 | Read data, registered one cycle after bus_re |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_err | input | 3 | Receive error flags {break, parity, framing} |
| tx_done | input | 1 | Transmitter finished one pending byte |
| hw_evt | input | 11 | Event pulses that set raw interrupt bits |
| tx_strobe | output | 1 | One-cycle pulse for a byte written to the data register |
| tx_byte | output | 8 | Byte being handed to the transmitter |
| irq | output | 6 | Interrupt lines, each through its own mask |

## Verification
The embedded assertions watch, on every cycle, that each interrupt line matches raw AND enable AND its line mask, that a clear write leaves none of its bits set, that a status-clear write empties the status register, that loopback never lets the fill grow, that an overflowing byte sets the overrun flag, and that the queue stays within its capacity and empties on a flush. Ordering of dropped and kept bytes, the threshold mapping for every level code, the effect of rewriting the same enable bit, transmit pending accounting and readback masking can only be shown by the bench. Its behavioural model tracks these scenarios and a long mixed stream of traffic and register writes.

// File: rtl/uart_rf_pkg.sv
`timescale 1ns/1ps
package uart_rf_pkg;
  // Register indices (byte offset >> 2)
  localparam int RI_DATA = 0;
  localparam int RI_STAT = 1;
  localparam int RI_FLAG = 6;
  localparam int RI_ILP  = 8;
  localparam int RI_IDIV = 9;
  localparam int RI_FDIV = 10;
  localparam int RI_LINE = 11;
  localparam int RI_CTRL = 12;
  localparam int RI_LVL  = 13;
  localparam int RI_MASK = 14;
  localparam int RI_RAW  = 15;
  localparam int RI_MIS  = 16;
  localparam int RI_ICLR = 17;
  localparam int RI_DMA  = 18;
  // Field positions and widths
  localparam int LINE_QEN_BIT  = 4;
  localparam int CTRL_LPBK_BIT = 7;
  localparam int STAT_OVR_BIT  = 3;
  localparam int IDIV_W = 16;
  localparam int FDIV_W = 6;
  localparam int ERR_W  = 3;
endpackage

// File: rtl/uart_rf_rxq.sv
`timescale 1ns/1ps
module uart_rf_rxq #(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 11,
  localparam int PW     = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               qen,
  input  logic               push,
  input  logic [ENTRY_W-1:0] din,
  input  logic               pop,
  output logic [ENTRY_W-1:0] head,
  output logic [PW:0]        cnt,
  output logic [PW:0]        cnt_nxt,
  output logic               full,
  output logic               empty
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PW-1:0]      rd_q;
  logic [PW:0]        cnt_q;
  logic [PW:0]        cap;
  logic [PW-1:0]      wr_ptr;

  assign cap    = qen ? (PW+1)'(DEPTH) : (PW+1)'(1);
  assign wr_ptr = rd_q + cnt_q[PW-1:0];   // wraps by masking
  assign full   = (cnt_q == cap);
  assign empty  = (cnt_q == '0);
  assign head   = mem[rd_q];
  assign cnt    = cnt_q;

  always_comb begin
    if (flush) cnt_nxt = '0;
    else       cnt_nxt = cnt_q + (PW+1)'(push) - (PW+1)'(pop);
  end

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (pop) rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_nxt;
    end
  end

  // R5
  cnt_le_cap_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= (PW+1)'(DEPTH));
  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt_q == '0));
endmodule

// File: rtl/uart_rf_irq.sv
`timescale 1ns/1ps
module uart_rf_irq #(
  parameter int NUM_IRQ = 6,
  parameter int RAW_W   = 11,
  parameter logic [NUM_IRQ*RAW_W-1:0] LINE_MASK = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RAW_W-1:0]   raw_nxt,
  input  logic [RAW_W-1:0]   en_nxt,
  output logic [NUM_IRQ-1:0] irq
);
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) irq[g] <= 1'b0;
      else     irq[g] <= |(raw_nxt & en_nxt & LINE_MASK[g*RAW_W +: RAW_W]);
    end
  end
endmodule

// File: rtl/uart_regfile.sv
`timescale 1ns/1ps
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 16,
  parameter int RAW_W   = 11,
  parameter int RX_BIT  = 4,
  parameter int NUM_IRQ = 6,
  parameter logic [NUM_IRQ*RAW_W-1:0] LINE_MASK =
    {11'h00F, 11'h780, 11'h040, 11'h020, 11'h010, 11'h7FF}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_we,
  input  logic               bus_re,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               rx_valid,
  input  logic [7:0]         rx_byte,
  input  logic [ERR_W-1:0]   rx_err,
  input  logic               tx_done,
  input  logic [RAW_W-1:0]   hw_evt,
  output logic               tx_strobe,
  output logic [7:0]         tx_byte,
  output logic [NUM_IRQ-1:0] irq
);
  localparam int PW    = $clog2(DEPTH);
  localparam int IDX_W = ADDR_W - 2;
  localparam int ENT_W = ERR_W + 8;

  logic [IDX_W-1:0] idx;
  logic             word_ok;
  assign idx     = bus_addr[ADDR_W-1:2];
  assign word_ok = (bus_addr[1:0] == 2'b00);

  logic wr_ok;
  assign wr_ok = bus_we && word_ok;
  logic wr_data, wr_stat, wr_ilp, wr_idiv, wr_fdiv, wr_line, wr_ctrl, wr_lvl, wr_mask, wr_iclr, wr_dma, rd_data;
  assign wr_data = wr_ok && (idx == IDX_W'(RI_DATA));
  assign wr_stat = wr_ok && (idx == IDX_W'(RI_STAT));
  assign wr_ilp  = wr_ok && (idx == IDX_W'(RI_ILP));
  assign wr_idiv = wr_ok && (idx == IDX_W'(RI_IDIV));
  assign wr_fdiv = wr_ok && (idx == IDX_W'(RI_FDIV));
  assign wr_line = wr_ok && (idx == IDX_W'(RI_LINE));
  assign wr_ctrl = wr_ok && (idx == IDX_W'(RI_CTRL));
  assign wr_lvl  = wr_ok && (idx == IDX_W'(RI_LVL));
  assign wr_mask = wr_ok && (idx == IDX_W'(RI_MASK));
  assign wr_iclr = wr_ok && (idx == IDX_W'(RI_ICLR));
  assign wr_dma  = wr_ok && (idx == IDX_W'(RI_DMA));
  assign rd_data = bus_re && word_ok && (idx == IDX_W'(RI_DATA));

  logic [7:0]        ilp_q, line_q;
  logic [IDIV_W-1:0] idiv_q;
  logic [FDIV_W-1:0] fdiv_q;
  logic [15:0]       ctrl_q;
  logic [5:0]        lvl_q;
  logic [RAW_W-1:0]  en_q, raw_q, en_n, raw_n;
  logic [2:0]        dma_q;
  logic [3:0]        stat_q, stat_n;
  logic [PW:0]       tx_cnt_q, tx_cnt_n, cap;

  function automatic logic [PW:0] thresh(input logic qen, input logic [2:0] code);
    if (!qen) return (PW+1)'(1);
    case (code)
      3'd0:    return (PW+1)'(DEPTH / 8);
      3'd1:    return (PW+1)'(DEPTH / 4);
      3'd2:    return (PW+1)'(DEPTH / 2);
      3'd3:    return (PW+1)'(DEPTH * 3 / 4);
      3'd4:    return (PW+1)'(DEPTH * 7 / 8);
      default: return (PW+1)'(DEPTH / 2);
    endcase
  endfunction

  // queue enable change flushes both directions
  logic flush, lpbk, rx_take, rx_push, rx_pop;
  logic rx_full, rx_empty;
  logic [ENT_W-1:0] rx_head;
  logic [PW:0] rx_cnt, rx_cnt_n, trig_n;
  assign flush   = wr_line && (bus_wdata[LINE_QEN_BIT] != line_q[LINE_QEN_BIT]);
  assign lpbk    = ctrl_q[CTRL_LPBK_BIT];
  assign rx_take = rx_valid && !lpbk;
  assign rx_push = rx_take && !rx_full && !flush;
  assign rx_pop  = rd_data && !rx_empty;
  assign cap     = line_q[LINE_QEN_BIT] ? (PW+1)'(DEPTH) : (PW+1)'(1);
  assign trig_n  = thresh(wr_line ? bus_wdata[LINE_QEN_BIT] : line_q[LINE_QEN_BIT],
                          wr_lvl ? bus_wdata[2:0] : lvl_q[2:0]);

  uart_rf_rxq #(.DEPTH(DEPTH), .ENTRY_W(ENT_W)) i_rxq (
    .clk(clk), .rst(rst), .flush(flush), .qen(line_q[LINE_QEN_BIT]),
    .push(rx_push), .din({rx_err, rx_byte}), .pop(rx_pop),
    .head(rx_head), .cnt(rx_cnt), .cnt_nxt(rx_cnt_n),
    .full(rx_full), .empty(rx_empty)
  );

  always_comb begin
    stat_n = stat_q;
    if (rx_take) begin
      if (rx_full) stat_n[STAT_OVR_BIT] = 1'b1;
      else         stat_n[ERR_W-1:0]    = stat_q[ERR_W-1:0] | rx_err;
    end
    if (wr_stat) stat_n = '0;
  end

  always_comb begin
    raw_n = raw_q;
    if (rx_push || rx_pop || flush || wr_line || wr_lvl)
      raw_n[RX_BIT] = (rx_cnt_n >= trig_n);
    raw_n = raw_n | hw_evt;
    if (wr_iclr) raw_n = raw_n & ~bus_wdata[RAW_W-1:0];
  end

  assign en_n = wr_mask ? bus_wdata[RAW_W-1:0] : en_q;

  always_comb begin
    if (flush) tx_cnt_n = '0;
    else tx_cnt_n = tx_cnt_q + (PW+1)'(wr_data && (tx_cnt_q != cap))
                             - (PW+1)'(tx_done && (tx_cnt_q != '0));
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (word_ok) begin
      case (idx)
        IDX_W'(RI_DATA): rd_mux = rx_empty ? '0 : DATA_W'(rx_head);
        IDX_W'(RI_STAT): rd_mux = DATA_W'(stat_q);
        IDX_W'(RI_FLAG): rd_mux = DATA_W'({tx_cnt_q == '0, rx_full, rx_empty});
        IDX_W'(RI_ILP):  rd_mux = DATA_W'(ilp_q);
        IDX_W'(RI_IDIV): rd_mux = DATA_W'(idiv_q);
        IDX_W'(RI_FDIV): rd_mux = DATA_W'(fdiv_q);
        IDX_W'(RI_LINE): rd_mux = DATA_W'(line_q);
        IDX_W'(RI_CTRL): rd_mux = DATA_W'(ctrl_q);
        IDX_W'(RI_LVL):  rd_mux = DATA_W'(lvl_q);
        IDX_W'(RI_MASK): rd_mux = DATA_W'(en_q);
        IDX_W'(RI_RAW):  rd_mux = DATA_W'(raw_q);
        IDX_W'(RI_MIS):  rd_mux = DATA_W'(raw_q & en_q);
        IDX_W'(RI_DMA):  rd_mux = DATA_W'(dma_q);
        default:         rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ilp_q <= '0; line_q <= '0; idiv_q <= '0; fdiv_q <= '0;
      ctrl_q <= '0; lvl_q <= '0; en_q <= '0; raw_q <= '0;
      dma_q <= '0; stat_q <= '0; tx_cnt_q <= '0;
      tx_strobe <= 1'b0; tx_byte <= '0; bus_rdata <= '0;
    end else begin
      if (wr_ilp)  ilp_q  <= bus_wdata[7:0];
      if (wr_idiv) idiv_q <= bus_wdata[IDIV_W-1:0];
      if (wr_fdiv) fdiv_q <= bus_wdata[FDIV_W-1:0];
      if (wr_line) line_q <= bus_wdata[7:0];
      if (wr_ctrl) ctrl_q <= bus_wdata[15:0];
      if (wr_lvl)  lvl_q  <= bus_wdata[5:0];
      if (wr_dma)  dma_q  <= bus_wdata[2:0];
      en_q      <= en_n;
      raw_q     <= raw_n;
      stat_q    <= stat_n;
      tx_cnt_q  <= tx_cnt_n;
      tx_strobe <= wr_data;
      if (wr_data) tx_byte <= bus_wdata[7:0];
      if (bus_re) bus_rdata <= rd_mux;
    end
  end

  uart_rf_irq #(.NUM_IRQ(NUM_IRQ), .RAW_W(RAW_W), .LINE_MASK(LINE_MASK)) i_irq (
    .clk(clk), .rst(rst), .raw_nxt(raw_n), .en_nxt(en_n), .irq(irq)
  );

  // R3
  stat_clr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stat |=> (stat_q == '0));
  // R9
  iclr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_iclr |=> ((raw_q & $past(bus_wdata[RAW_W-1:0])) == '0));
  // R11
  lpbk_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (lpbk && rx_valid) |=> (rx_cnt <= $past(rx_cnt)));
  // R5
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_take && rx_full && !wr_stat) |=> stat_q[STAT_OVR_BIT]);
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line_chk
    // R10
    irq_line_chk: assert property (@(posedge clk) disable iff (rst)
      irq[g] == (|(raw_q & en_q & LINE_MASK[g*RAW_W +: RAW_W])));
  end
endmodule

// File: tb/test_uart_regfile.sv
`timescale 1ns/1ps
module test_uart_regfile;
  localparam int ADDR_W = 8, DATA_W = 16, DEPTH = 16, RAW_W = 11, NUM_IRQ = 6;
  localparam logic [NUM_IRQ*RAW_W-1:0] LMASK =
    {11'h00F, 11'h780, 11'h040, 11'h020, 11'h010, 11'h7FF};

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0, bus_rdata;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic rx_valid = 1'b0, tx_done = 1'b0;
  logic [7:0] rx_byte = '0, tx_byte;
  logic [2:0] rx_err = '0;
  logic [RAW_W-1:0] hw_evt = '0;
  logic tx_strobe;
  logic [NUM_IRQ-1:0] irq;

  uart_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .RAW_W(RAW_W),
                 .NUM_IRQ(NUM_IRQ), .LINE_MASK(LMASK)) i_uart_regfile (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_err(rx_err), .tx_done(tx_done),
    .hw_evt(hw_evt), .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // behavioural reference state
  logic [10:0] m_q[$];
  int m_tx;
  logic [7:0] m_ilp, m_line;
  logic [15:0] m_idiv, m_ctrl;
  logic [5:0] m_fdiv, m_lvl;
  logic [2:0] m_dma;
  logic [3:0] m_stat;
  logic [RAW_W-1:0] m_raw, m_en;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int m_cap();
    return m_line[4] ? DEPTH : 1;
  endfunction

  function automatic int m_thr(logic qen, logic [2:0] c);
    if (!qen) return 1;
    case (c)
      0: return 2; 1: return 4; 2: return 8; 3: return 12; 4: return 14;
      default: return 8;
    endcase
  endfunction

  function automatic logic [15:0] m_read(int idx);
    case (idx)
      0: return (m_q.size() == 0) ? 16'h0 : {5'b0, m_q[0]};
      1: return {12'b0, m_stat};
      6: return {13'b0, (m_tx == 0), (m_q.size() == m_cap()), (m_q.size() == 0)};
      8: return {8'b0, m_ilp};
      9: return m_idiv;
      10: return {10'b0, m_fdiv};
      11: return {8'b0, m_line};
      12: return m_ctrl;
      13: return {10'b0, m_lvl};
      14: return {5'b0, m_en};
      15: return {5'b0, m_raw};
      16: return {5'b0, m_raw & m_en};
      18: return {13'b0, m_dma};
      default: return 16'h0;
    endcase
  endfunction

  task automatic m_reset();
    m_q.delete(); m_tx = 0; m_ilp = 0; m_line = 0; m_idiv = 0; m_ctrl = 0;
    m_fdiv = 0; m_lvl = 0; m_dma = 0; m_stat = 0; m_raw = 0; m_en = 0;
  endtask

  // one bus/stimulus cycle; model and DUT compared after every edge
  task automatic step(string tag, bit we, bit re, int idx, logic [15:0] wd,
                      bit rxv = 0, logic [7:0] rxb = 0, logic [2:0] rxe = 0,
                      bit txd = 0, logic [RAW_W-1:0] evt = '0, bit misal = 0);
    logic [15:0] rexp;
    bit flush, take, pop, push, full, wr, txinc, txdec;
    int cap;
    logic [NUM_IRQ-1:0] iexp;
    bus_addr = ADDR_W'(idx * 4 + (misal ? 1 : 0));
    bus_wdata = wd; bus_we = we; bus_re = re;
    rx_valid = rxv; rx_byte = rxb; rx_err = rxe; tx_done = txd; hw_evt = evt;
    @(posedge clk);
    wr = we && !misal;
    cap = m_cap();
    full = (m_q.size() == cap);
    rexp = misal ? 16'h0 : m_read(idx);
    flush = wr && idx == 11 && (wd[4] != m_line[4]);
    take = rxv && !m_ctrl[7];
    pop = re && !misal && idx == 0 && m_q.size() > 0;
    push = take && !full && !flush;
    txinc = wr && idx == 0 && m_tx < cap;
    txdec = txd && m_tx > 0;
    if (take) begin
      if (full) m_stat[3] = 1'b1;
      else m_stat[2:0] = m_stat[2:0] | rxe;
    end
    if (wr && idx == 1) m_stat = 0;
    if (flush) begin
      m_q.delete(); m_tx = 0;
    end else begin
      if (pop) void'(m_q.pop_front());
      if (push) m_q.push_back({rxe, rxb});
      m_tx = m_tx + int'(txinc) - int'(txdec);
    end
    if (wr) case (idx)
      8: m_ilp = wd[7:0];
      9: m_idiv = wd;
      10: m_fdiv = wd[5:0];
      11: m_line = wd[7:0];
      12: m_ctrl = wd;
      13: m_lvl = wd[5:0];
      14: m_en = wd[RAW_W-1:0];
      18: m_dma = wd[2:0];
      default: ;
    endcase
    if (push || pop || flush || (wr && (idx == 11 || idx == 13)))
      m_raw[4] = (m_q.size() >= m_thr(m_line[4], m_lvl[2:0]));
    m_raw = m_raw | evt;
    if (wr && idx == 17) m_raw = m_raw & ~wd[RAW_W-1:0];
    for (int i = 0; i < NUM_IRQ; i++)
      iexp[i] = |(m_raw & m_en & LMASK[i*RAW_W +: RAW_W]);
    #1;
    chk(tag, "irq", 32'(irq), 32'(iexp));
    chk(tag, "tx_strobe", 32'(tx_strobe), 32'(wr && idx == 0));
    if (wr && idx == 0) chk(tag, "tx_byte", 32'(tx_byte), 32'(wd[7:0]));
    if (re) chk(tag, $sformatf("rdata idx %0d", idx), 32'(bus_rdata), 32'(rexp));
    bus_we = 0; bus_re = 0; rx_valid = 0; tx_done = 0; hw_evt = '0;
  endtask

  task automatic wr_reg(string tag, int idx, logic [15:0] wd);
    step(tag, 1, 0, idx, wd);
  endtask
  task automatic rd_reg(string tag, int idx);
    step(tag, 0, 1, idx, 16'h0);
  endtask
  task automatic rx_in(string tag, logic [7:0] b, logic [2:0] e = 0);
    step(tag, 0, 0, 0, 16'h0, 1, b, e);
  endtask

  function automatic int regs_list(int k);
    case (k) 0: return 8; 1: return 9; 2: return 10; 3: return 11; 4: return 12;
      5: return 13; 6: return 14; default: return 18; endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    chk("R1", "irq after reset", 32'(irq), 0);
    rd_reg("R1", 6);
    chk("R1", "flags literal", 32'(bus_rdata), 32'h5);
    for (int k = 0; k < 8; k++) rd_reg("R1", regs_list(k));
    rd_reg("R1", 1); rd_reg("R1", 15);

    // R2 readback with field masks
    wr_reg("R2", 9, 16'hFFFF);  rd_reg("R2", 9);
    wr_reg("R2", 10, 16'hFFFF); rd_reg("R2", 10);
    chk("R2", "fractional mask literal", 32'(bus_rdata), 32'h3F);
    wr_reg("R2", 8, 16'hA5C3);  rd_reg("R2", 8);
    wr_reg("R2", 13, 16'hFFC1); rd_reg("R2", 13);
    wr_reg("R2", 18, 16'hFFFF); rd_reg("R2", 18);
    wr_reg("R2", 12, 16'h1234); rd_reg("R2", 12);
    wr_reg("R2", 12, 16'h0000);
    wr_reg("R2", 13, 16'h0000);

    // R4 ignored writes
    wr_reg("R4", 6, 16'hFFFF);
    wr_reg("R4", 7, 16'hFFFF);
    wr_reg("R4", 19, 16'hFFFF);
    wr_reg("R4", 63, 16'hFFFF);
    step("R4", 1, 0, 9, 16'h0001, .misal(1));
    step("R4", 1, 0, 14, 16'h07FF, .misal(1));
    for (int k = 0; k < 8; k++) rd_reg("R4", regs_list(k));
    rd_reg("R4", 6);

    // R5 single-entry queue, overrun; R8 threshold of one
    wr_reg("R10", 14, 16'h07FF);
    rx_in("R5", 8'h11, 3'b010);
    rd_reg("R8", 15);
    rx_in("R5", 8'h22);
    rd_reg("R5", 1);
    chk("R5", "overrun literal", 32'(bus_rdata), 32'hA);
    rd_reg("R5", 6);
    // R3 any value clears status
    wr_reg("R3", 1, 16'h0000);
    rd_reg("R3", 1);
    rx_in("R3", 8'h33, 3'b101);
    wr_reg("R3", 1, 16'hBEEF);
    rd_reg("R3", 1);
    rd_reg("R5", 0);
    chk("R5", "single entry literal", 32'(bus_rdata), 32'h211);
    rd_reg("R5", 0);

    // R6 enable change flushes; R7 thresholds; R8 re-evaluation
    rx_in("R6", 8'h44);
    wr_reg("R6", 11, 16'h0010);
    rd_reg("R6", 6);
    rd_reg("R8", 15);
    wr_reg("R7", 13, 16'h0001);
    for (int k = 0; k < 4; k++) begin rx_in("R7", 8'(k)); rd_reg("R8", 15); end
    rd_reg("R8", 0);
    rd_reg("R8", 15);
    for (int c = 0; c < 8; c++) begin
      wr_reg("R7", 13, 16'(c));
      rd_reg("R7", 15);
    end
    wr_reg("R7", 13, 16'h0004);
    for (int k = 0; k < 16; k++) begin rx_in("R5", 8'h80 + 8'(k), 3'(k)); rd_reg("R7", 16); end
    rd_reg("R5", 6);
    rx_in("R5", 8'hEE);
    rd_reg("R5", 1);
    wr_reg("R6", 11, 16'h0090);   // same enable bit, other bits
    rd_reg("R6", 6);
    for (int k = 0; k < 17; k++) rd_reg("R5", 0);
    rx_in("R6", 8'h55);
    step("R6", 1, 0, 0, 16'h0066);
    wr_reg("R6", 11, 16'h0000);
    rd_reg("R6", 6);
    chk("R6", "flush literal", 32'(bus_rdata), 32'h5);

    // R9 events and write-one clear
    step("R9", 0, 0, 0, 16'h0, .evt(11'h5A3));
    rd_reg("R9", 15);
    wr_reg("R9", 17, 16'h0083);
    rd_reg("R9", 15);
    step("R9", 1, 0, 17, 16'h0020, .evt(11'h021));
    rd_reg("R9", 15);

    // R10 enable replacement and per-line masks
    wr_reg("R10", 14, 16'h0000);
    wr_reg("R10", 14, 16'h0400);
    wr_reg("R10", 14, 16'h0001);
    step("R10", 0, 0, 0, 16'h0, .evt(11'h040));
    wr_reg("R10", 14, 16'h0040);
    rd_reg("R10", 16);
    wr_reg("R9", 17, 16'h07FF);
    wr_reg("R10", 14, 16'h07FF);

    // R11 loopback drops input
    wr_reg("R11", 12, 16'h0080);
    rx_in("R11", 8'h77, 3'b111);
    rd_reg("R11", 6);
    rd_reg("R11", 1);
    wr_reg("R11", 12, 16'h0000);
    rx_in("R11", 8'h78);
    rd_reg("R11", 0);

    // R12 transmit pending accounting
    step("R12", 1, 0, 0, 16'h00A7);
    rd_reg("R12", 6);
    step("R12", 1, 0, 0, 16'h0042);
    rd_reg("R12", 6);
    step("R12", 0, 0, 0, 16'h0, .txd(1));
    rd_reg("R12", 6);
    step("R12", 0, 0, 0, 16'h0, .txd(1));
    step("R12", 0, 0, 0, 16'h0, .txd(1));
    rd_reg("R12", 6);

    // mixed traffic
    wr_reg("R8", 11, 16'h0010);
    for (int k = 0; k < 600; k++) begin
      int r;
      r = int'($urandom_range(0, 9));
      case (r)
        0, 1, 2: rx_in("R8", 8'($urandom), 3'($urandom));
        3, 4: rd_reg("R5", 0);
        5: wr_reg("R9", 17, 16'($urandom));
        6: wr_reg("R10", 14, 16'($urandom));
        7: step("R9", 0, 0, 0, 16'h0, .evt(RAW_W'($urandom) & RAW_W'($urandom)));
        8: wr_reg("R7", 13, 16'($urandom_range(0, 7)));
        default: if ($urandom_range(0, 3) == 0) wr_reg("R6", 11, 16'($urandom_range(0, 1)) << 4);
                 else rd_reg("R8", int'($urandom_range(1, 18)));
      endcase
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule